// File: doc/BRIEF.md
# PWM Configuration Two-Wire Slave

This block is the serial front end of a small pulse-width modulator. It listens on a two-wire bus: SCL is an input only, and SDA is open-drain. Both lines are brought in through synchronizers and sampled on a fast system clock. The block finds START, repeated START and STOP conditions. It checks the first byte of each transfer against a fixed four-bit type code and three pin-strapped select inputs, so up to eight of these slaves can share one bus.

On a write, each following byte is a command. A command can load a duty value, force full duty, enter shutdown or leave it. On a read, the block returns its configuration byte. It keeps sending that byte until the master answers with no acknowledge.

The duty value, full-on flag, shutdown level and recall strobe drive a separate PWM stage. SDA is modelled as a sampled input `sda_in` plus an enable `sda_oe`. When `sda_oe` is set, the pad pulls the line low.

Top module: `pwm_cfg_twi_slave`

## Requirements
- R1: After reset `duty` is 0, `full_on` is 0, `shutdown` is 0, `recall_pulse` is 0, and SDA is released (`sda_oe` = 0).
- R2: A START followed by a control byte, sent MSB first, whose bits [7:4] equal 4'b0101 and whose bits [3:1] equal `sel[2:0]` is acknowledged: SDA is held low through the ninth SCL high phase. Bit 0 of that byte selects a read (1) or a write (0).
- R3: A control byte whose type code or select bits differ gets no acknowledge. Every later byte up to the next START gets no acknowledge and changes no output.
- R4: A write command byte with bits [7:5] = 3'b100 loads `duty` from bits [4:0] and clears `full_on`. The byte is acknowledged.
- R5: A command byte with bits [7:5] = 3'b101 sets `full_on` and leaves `duty` unchanged.
- R6: A command byte with bits [7:5] = 3'b110 sets `shutdown`. A command byte with bits [7:5] = 3'b111 clears `shutdown` and raises `recall_pulse` for exactly one clock.
- R7: A command byte with bit 7 = 0 is acknowledged and changes no output.
- R8: Several command bytes in one write transfer are each acknowledged and each applied, in order.
- R9: In a read, the slave sends {full_on, shutdown, 1'b0, duty[4:0]} MSB first. It changes `sda_oe` only while SCL is low.
- R10: An acknowledge from the master makes the slave send the configuration byte again. A no-acknowledge makes it release SDA until the next START.
- R11: A repeated START in the middle of a transfer restarts address matching without any STOP. A write followed by a repeated START and a read returns the value just written.
- R12: A STOP in the middle of a byte releases SDA and discards the partly received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock as seen at the pad |
| sda_in | input | 1 | Bus data as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| sel | input | 3 | Pin-strapped select bits |
| duty | output | DUTY_W | Duty step for the PWM stage |
| full_on | output | 1 | Force 100% duty |
| shutdown | output | 1 | Low-current mode request |
| recall_pulse | output | 1 | One-clock strobe on leaving shutdown |

## Verification
The bench covers wrong type codes and wrong select bits, both at the ACK and at the outputs. A slave that matched too loosely would acknowledge a byte meant for another device and would accept the duty command that follows. It also covers a repeated START placed straight after a write. A design that waited for STOP would miss the read address and return all ones. A STOP is placed halfway through a command byte. A design that applied partial bytes would corrupt `duty`. After a master no-acknowledge, the bench clocks one more byte. A slave that kept transmitting would pull SDA low where the bench expects 0xFF.

// File: rtl/twi_cfg_pkg.sv
package twi_cfg_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK_WAIT,
      ST_ACK_HOLD,
      ST_CMD,
      ST_TX,
      ST_MACK
   } twi_state_e;

   localparam logic [2:0] OP_DUTY   = 3'b100;
   localparam logic [2:0] OP_FULL   = 3'b101;
   localparam logic [2:0] OP_SHDN   = 3'b110;
   localparam logic [2:0] OP_RECALL = 3'b111;
endpackage

// File: rtl/twi_line_cond.sv
module twi_line_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_hi,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
   logic scl_q, sda_q;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("SYNC_STAGES must be at least 2");
   end

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            scl_pipe[g] <= 1'b1;
            sda_pipe[g] <= 1'b1;
         end else if (g == 0) begin
            scl_pipe[g] <= scl_in;
            sda_pipe[g] <= sda_in;
         end else begin
            scl_pipe[g] <= scl_pipe[(g == 0) ? 0 : g-1];
            sda_pipe[g] <= sda_pipe[(g == 0) ? 0 : g-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_pipe[SYNC_STAGES-1];
         sda_q <= sda_pipe[SYNC_STAGES-1];
      end
   end

   assign scl_hi    = scl_pipe[SYNC_STAGES-1];
   assign sda_s     = sda_pipe[SYNC_STAGES-1];
   assign scl_rise  = scl_hi & ~scl_q;
   assign scl_fall  = ~scl_hi & scl_q;
   assign start_det = scl_hi & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_hi & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
   import twi_cfg_pkg::*;
#(
   parameter logic [3:0] TYPE_CODE = 4'b0101
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_hi,
   input  logic       sda_s,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic [2:0] sel,
   input  logic [7:0] rd_byte,
   output logic       cmd_valid,
   output logic [7:0] cmd_byte,
   output logic       sda_oe
);
   twi_state_e state;
   logic [3:0] bit_cnt;
   logic [6:0] shreg;
   logic [7:0] txsh;
   logic       rw_q;
   logic [7:0] rx_byte;
   logic       addr_hit;

   assign rx_byte  = {shreg, sda_s};
   assign addr_hit = (rx_byte[7:1] == {TYPE_CODE, sel});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bit_cnt   <= '0;
         shreg     <= '0;
         txsh      <= '0;
         rw_q      <= 1'b0;
         sda_oe    <= 1'b0;
         cmd_valid <= 1'b0;
         cmd_byte  <= '0;
      end else begin
         cmd_valid <= 1'b0;
         if (start_det) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR, ST_CMD: if (scl_rise) begin
                  shreg <= rx_byte[6:0];
                  if (bit_cnt == 4'd7) begin
                     bit_cnt <= '0;
                     if (state == ST_ADDR) begin
                        rw_q  <= rx_byte[0];
                        state <= addr_hit ? ST_ACK_WAIT : ST_IDLE;
                     end else begin
                        cmd_valid <= 1'b1;
                        cmd_byte  <= rx_byte;
                        state     <= ST_ACK_WAIT;
                     end
                  end else begin
                     bit_cnt <= bit_cnt + 4'd1;
                  end
               end
               ST_ACK_WAIT: if (scl_fall) begin
                  sda_oe <= 1'b1;
                  state  <= ST_ACK_HOLD;
               end
               ST_ACK_HOLD: if (scl_fall) begin
                  if (rw_q) begin
                     sda_oe  <= ~rd_byte[7];
                     txsh    <= {rd_byte[6:0], 1'b0};
                     bit_cnt <= 4'd1;
                     state   <= ST_TX;
                  end else begin
                     sda_oe  <= 1'b0;
                     bit_cnt <= '0;
                     state   <= ST_CMD;
                  end
               end
               ST_TX: if (scl_fall) begin
                  if (bit_cnt == 4'd8) begin
                     sda_oe <= 1'b0;
                     state  <= ST_MACK;
                  end else begin
                     sda_oe  <= ~txsh[7];
                     txsh    <= {txsh[6:0], 1'b0};
                     bit_cnt <= bit_cnt + 4'd1;
                  end
               end
               ST_MACK: if (scl_rise) begin
                  if (sda_s) begin
                     state <= ST_IDLE;
                  end else begin
                     txsh    <= rd_byte;
                     bit_cnt <= '0;
                     state   <= ST_TX;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // R12: a STOP always leaves SDA released
   a_r12_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);
   // R9: the slave only starts pulling SDA while SCL is low
   a_r9_pull_in_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_hi);
   // R3: an idle slave never drives the bus
   a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);
   // R2: a byte is handed over only after the address phase has passed
   a_r2_cmd_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (state == ST_ACK_WAIT));
endmodule

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
   import twi_cfg_pkg::*;
#(
   parameter int DUTY_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_byte,
   output logic [DUTY_W-1:0] duty,
   output logic              full_on,
   output logic              shutdown,
   output logic              recall_pulse,
   output logic [7:0]        rd_byte
);
   localparam int PAD_W = 6 - DUTY_W;

   if (DUTY_W < 1 || DUTY_W > 5) begin : g_bad_duty
      $error("DUTY_W must lie in 1..5");
   end

   logic [2:0] op;
   assign op = cmd_byte[7:5];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         duty         <= '0;
         full_on      <= 1'b0;
         shutdown     <= 1'b0;
         recall_pulse <= 1'b0;
      end else begin
         recall_pulse <= 1'b0;
         if (cmd_valid) begin
            case (op)
               OP_DUTY: begin
                  duty    <= cmd_byte[DUTY_W-1:0];
                  full_on <= 1'b0;
               end
               OP_FULL:  full_on  <= 1'b1;
               OP_SHDN:  shutdown <= 1'b1;
               OP_RECALL: begin
                  shutdown     <= 1'b0;
                  recall_pulse <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   assign rd_byte = {full_on, shutdown, {PAD_W{1'b0}}, duty};

   // R7: outputs move only on an accepted command byte
   a_r7_hold_without_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> ($stable(duty) && $stable(full_on) && $stable(shutdown)));
   // R6: the recall strobe coincides with shutdown being cleared
   a_r6_recall_clears: assert property (@(posedge clk) disable iff (!rst_n)
      recall_pulse |-> !shutdown);
   // R6: the strobe lasts one clock
   a_r6_recall_single: assert property (@(posedge clk) disable iff (!rst_n)
      recall_pulse |=> !recall_pulse);
endmodule

// File: rtl/pwm_cfg_twi_slave.sv
module pwm_cfg_twi_slave #(
   parameter int         DUTY_W      = 5,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] TYPE_CODE   = 4'b0101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_oe,
   input  logic [2:0]        sel,
   output logic [DUTY_W-1:0] duty,
   output logic              full_on,
   output logic              shutdown,
   output logic              recall_pulse
);
   logic scl_hi, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic cmd_valid;
   logic [7:0] cmd_byte, rd_byte;

   twi_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_hi(scl_hi), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   twi_slave_fsm #(.TYPE_CODE(TYPE_CODE)) u_fsm (
      .clk(clk), .rst_n(rst_n), .scl_hi(scl_hi), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
      .stop_det(stop_det), .sel(sel), .rd_byte(rd_byte),
      .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .sda_oe(sda_oe)
   );

   pwm_cfg_regs #(.DUTY_W(DUTY_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .duty(duty), .full_on(full_on), .shutdown(shutdown),
      .recall_pulse(recall_pulse), .rd_byte(rd_byte)
   );
endmodule

// File: tb/pwm_cfg_twi_slave_bench.sv
module pwm_cfg_twi_slave_bench;
   localparam int Q = 8;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m_low = 1'b0;
   logic [2:0] sel = 3'b101;
   logic sda_oe, full_on, shutdown, recall_pulse;
   logic [4:0] duty;
   logic sda_bus;
   int checks = 0, fails = 0, recalls = 0, hi_changes = 0;
   bit done = 0;
   string rq[$];
   int    vq[$];

   always #4 clk = ~clk;
   assign sda_bus = ~(sda_m_low | sda_oe);

   pwm_cfg_twi_slave u_pwm_cfg_twi_slave (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
      .sda_oe(sda_oe), .sel(sel), .duty(duty), .full_on(full_on),
      .shutdown(shutdown), .recall_pulse(recall_pulse)
   );

   logic oe_prev = 1'b0, scl_prev = 1'b1;
   always @(negedge clk) begin
      if (recall_pulse) recalls++;
      if (rst_n && sda_oe != oe_prev && scl_m && scl_prev) hi_changes++;
      oe_prev  = sda_oe;
      scl_prev = scl_m;
   end

   task automatic expect_val(input string r, input int v);
      rq.push_back(r);
      vq.push_back(v);
   endtask

   task automatic observe(input int actual);
      string r = rq.pop_front();
      int    v = vq.pop_front();
      checks++;
      if (actual != v) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", r, actual, v);
      end
   endtask

   task automatic wait_q;
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start;
      sda_m_low = 1'b0; wait_q; scl_m = 1'b1; wait_q;
      sda_m_low = 1'b1; wait_q; scl_m = 1'b0; wait_q;
   endtask

   task automatic bus_stop;
      sda_m_low = 1'b1; wait_q; scl_m = 1'b1; wait_q;
      sda_m_low = 1'b0; wait_q;
   endtask

   task automatic put_bit(input logic b);
      sda_m_low = ~b; wait_q; scl_m = 1'b1; wait_q; wait_q;
      scl_m = 1'b0; wait_q;
   endtask

   task automatic get_bit(output logic b);
      sda_m_low = 1'b0; wait_q; scl_m = 1'b1; wait_q;
      b = sda_bus; wait_q; scl_m = 1'b0; wait_q;
   endtask

   task automatic put_byte(input logic [7:0] v, output logic ack_n);
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(ack_n);
   endtask

   task automatic get_byte(input logic nack, output logic [7:0] v);
      for (int i = 7; i >= 0; i--) get_bit(v[i]);
      put_bit(nack);
   endtask

   task automatic check_outs(input string r, input int d, input int f, input int s);
      expect_val(r, d); observe(duty);
      expect_val(r, f); observe(full_on);
      expect_val(r, s); observe(shutdown);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic a;
      logic [7:0] rb;
      repeat (5) @(negedge clk);
      // R1 reset state
      check_outs("R1", 0, 0, 0);
      expect_val("R1", 0); observe(sda_oe);
      expect_val("R1", 0); observe(recall_pulse);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R2, R4: address ack then duty load
      bus_start;
      put_byte(8'h5A, a); expect_val("R2 addr ack", 0); observe(a);
      put_byte(8'h93, a); expect_val("R4 cmd ack", 0); observe(a);
      bus_stop;
      check_outs("R4", 5'h13, 0, 0);

      // R5, R6, R8: two commands in one transfer
      bus_start;
      put_byte(8'h5A, a);
      put_byte(8'hA0, a); expect_val("R8 first ack", 0); observe(a);
      put_byte(8'hC0, a); expect_val("R8 second ack", 0); observe(a);
      bus_stop;
      check_outs("R5 R6 R8", 5'h13, 1, 1);

      // R9, R10: read twice, then release after NACK
      bus_start;
      put_byte(8'h5B, a); expect_val("R2 read ack", 0); observe(a);
      get_byte(1'b0, rb); expect_val("R9 read byte", 8'hD3); observe(rb);
      get_byte(1'b1, rb); expect_val("R10 repeat byte", 8'hD3); observe(rb);
      get_byte(1'b1, rb); expect_val("R10 released", 8'hFF); observe(rb);
      bus_stop;

      // R6: recall
      bus_start;
      put_byte(8'h5A, a);
      put_byte(8'hE0, a);
      bus_stop;
      check_outs("R6 recall", 5'h13, 1, 0);
      expect_val("R6 pulse count", 1); observe(recalls);

      // R7: bit 7 clear is a no-op
      bus_start;
      put_byte(8'h5A, a);
      put_byte(8'h3F, a); expect_val("R7 ack", 0); observe(a);
      bus_stop;
      check_outs("R7", 5'h13, 1, 0);

      // R3: wrong type code, then wrong select bits
      bus_start;
      put_byte(8'h7A, a); expect_val("R3 type nack", 1); observe(a);
      put_byte(8'h85, a); expect_val("R3 data nack", 1); observe(a);
      bus_stop;
      bus_start;
      put_byte(8'h58, a); expect_val("R3 select nack", 1); observe(a);
      put_byte(8'h81, a); expect_val("R3 data nack 2", 1); observe(a);
      bus_stop;
      check_outs("R3", 5'h13, 1, 0);

      // R11: write, repeated START, read back
      bus_start;
      put_byte(8'h5A, a);
      put_byte(8'h85, a);
      bus_start;
      put_byte(8'h5B, a); expect_val("R11 read ack", 0); observe(a);
      get_byte(1'b1, rb); expect_val("R11 readback", 8'h05); observe(rb);
      bus_stop;

      // R12: STOP halfway through a command byte
      bus_start;
      put_byte(8'h5A, a);
      put_bit(1'b1); put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
      bus_stop;
      repeat (4) @(negedge clk);
      check_outs("R12", 5'h05, 0, 0);
      expect_val("R12 released", 0); observe(sda_oe);

      // R9: no SDA change by the slave while SCL high
      expect_val("R9 scl-high changes", 0); observe(hi_changes);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule